// File: doc/BRIEF.md
# Fractional Baud Rate Generator

This block turns one of four prescaler strobes into the baud tick that drives a serial channel. A 2-bit source select picks the strobe, and a 4-bit integer divisor N sets the base division. An optional fractional mode makes the average ratio N + (16-K)/16. It does this by lengthening some output periods by one input strobe. A first-order 4-bit phase accumulator spreads those longer periods evenly across each run of sixteen periods.

Software sets the block up through two byte registers, a control byte and a fraction byte. It writes them through a simple write strobe with a register select, and reads them back through a registered read port. A mode input says whether the channel runs as a UART or as a synchronous I/O interface. The block uses it to refuse settings that are illegal in the current mode. Any register write restarts the divide count and the phase accumulator, so the first baud tick after a reconfiguration comes at a known place.

Top module: `frac_baud_gen`

## Requirements
- R1: `pre_tick[i]` is prescaler strobe i: strobe 0 is undivided, 1 is divide-by-2, 2 is divide-by-8 and 3 is divide-by-32. The select field picks strobe i for code i (00, 01, 10, 11). Only the selected strobe advances the divider.
- R2: The divisor field gives N = 1..15 for codes 1..15, and code 0 gives N = 16. With fractional division inactive, one baud tick is produced for every N selected strobes.
- R3: Fractional division is active when the enable bit is 1, K is not 0 and `uart_mode` is 1. While it is active, every period lasts N or N+1 selected strobes, and any 16 consecutive periods that begin after the first period following a restart total 16*N + (16-K) strobes.
- R4: With K = 0 the enable bit has no effect, and the block divides by N.
- R5: While `uart_mode` is 0 (synchronous I/O mode), the block divides by N whatever the enable bit and K hold.
- R6: N = 1 is legal only when `uart_mode` is 1 and fractional division is inactive. In that case a tick follows every selected strobe. In every other case where N = 1, `baud_tick` stays 0.
- R7: `baud_tick` is high for exactly one clock, in the cycle after the clock edge that samples the strobe completing a period.
- R8: Any register write restarts the count. `baud_tick` is 0 in the cycle after the write edge, and the first tick follows the N-th selected strobe sampled after that edge.
- R9: Control byte layout: N in bits 3:0, source select in bits 5:4, fractional enable in bit 6, and bit 7 unused. Fraction byte layout: K in bits 3:0, with bits 7:4 unused. Writing unused bits has no effect, and they read back as 0.
- R10: `wr_sel` and `rd_sel` pick the register: 0 is control and 1 is fraction. `rd_data` is registered and shows the selected register one clock after `rd_sel` is sampled.
- R11: Synchronous reset clears both registers and `baud_tick`. After reset the block therefore divides strobe 0 by 16.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| uart_mode | input | 1 | 1 = UART mode, 0 = synchronous I/O mode |
| pre_tick | input | 4 | Prescaler strobes, one clock wide each |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 control, 1 fraction |
| wr_data | input | 8 | Write data |
| rd_sel | input | 1 | Read target: 0 control, 1 fraction |
| rd_data | output | 8 | Registered read data |
| baud_tick | output | 1 | One-clock baud tick |

## Verification
A baud tick shows up one clock after the edge that samples its completing strobe. Read data shows up one clock after `rd_sel` is sampled. The bench drives inputs on falling edges and samples one falling edge after each rising edge, so it counts latencies and periods in whole clock edges. Each period is measured as the number of falling edges between two ticks. The first period after a write is thrown away, because its length depends on the phase of the prescaler strobes. Restart latency is measured on strobe 0, where the tick must appear exactly N edges after the write edge.

// File: rtl/fbg_pkg.sv
package fbg_pkg;
  localparam int SRC_NUM = 4;
  localparam int SEL_W   = 2;
  localparam int DIV_W   = 4;
  localparam int FRAC_W  = 4;
  localparam int DATA_W  = 8;
  localparam int CNT_W   = DIV_W + 1;
  localparam int DIV_MAX = 1 << DIV_W;
  localparam int SRC_LSB = DIV_W;
  localparam int EN_BIT  = DIV_W + SEL_W;

  typedef struct packed {
    logic              frac_en;
    logic [SEL_W-1:0]  src;
    logic [DIV_W-1:0]  n;
    logic [FRAC_W-1:0] k;
  } cfg_t;
endpackage

// File: rtl/fbg_regs.sv
module fbg_regs
  import fbg_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_sel,
  output cfg_t              cfg,
  output logic              restart,
  output logic [DATA_W-1:0] rd_data
);
  logic unused_hi;
  assign unused_hi = ^wr_data[DATA_W-1:EN_BIT+1];

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg     <= '0;
      rd_data <= '0;
    end else begin
      if (wr_en) begin
        if (wr_sel) begin
          cfg.k <= wr_data[FRAC_W-1:0];
        end else begin
          cfg.n       <= wr_data[DIV_W-1:0];
          cfg.src     <= wr_data[SRC_LSB +: SEL_W];
          cfg.frac_en <= wr_data[EN_BIT];
        end
      end
      rd_data <= rd_sel ? DATA_W'(cfg.k) : DATA_W'({cfg.frac_en, cfg.src, cfg.n});
    end
  end

  assign restart = wr_en;
endmodule

// File: rtl/fbg_tick_sel.sv
module fbg_tick_sel
  import fbg_pkg::*;
(
  input  logic [SRC_NUM-1:0] pre_tick,
  input  logic [SEL_W-1:0]   sel,
  output logic               src_tick
);
  logic [SRC_NUM-1:0] hit;

  for (genvar i = 0; i < SRC_NUM; i++) begin : g_src
    assign hit[i] = pre_tick[i] & (sel == SEL_W'(i));
  end

  assign src_tick = |hit;
endmodule

// File: rtl/fbg_legal.sv
module fbg_legal
  import fbg_pkg::*;
(
  input  logic [DIV_W-1:0]  n,
  input  logic [FRAC_W-1:0] k,
  input  logic              frac_en,
  input  logic              uart_mode,
  output logic [CNT_W-1:0]  eff_n,
  output logic [FRAC_W-1:0] step,
  output logic              frac_act,
  output logic              n_bad
);
  assign eff_n    = (n == '0) ? CNT_W'(DIV_MAX) : CNT_W'(n);
  assign frac_act = frac_en && (k != '0) && uart_mode;
  assign n_bad    = (n == DIV_W'(1)) && (!uart_mode || frac_act);
  // modulo-16 complement: 16-K for K in 1..15
  assign step     = -k;
endmodule

// File: rtl/fbg_divider.sv
module fbg_divider
  import fbg_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              restart,
  input  logic              hold,
  input  logic              src_tick,
  input  logic              frac_act,
  input  logic [CNT_W-1:0]  eff_n,
  input  logic [FRAC_W-1:0] step,
  output logic              baud_tick
);
  logic [CNT_W-1:0]  cnt;
  logic [CNT_W-1:0]  target;
  logic [FRAC_W-1:0] acc;
  logic              stretch;
  logic [FRAC_W:0]   acc_sum;

  assign target  = eff_n + CNT_W'(frac_act & stretch);
  assign acc_sum = {1'b0, acc} + {1'b0, step};

  always_ff @(posedge clk) begin
    if (rst || restart || hold) begin
      cnt       <= '0;
      acc       <= '0;
      stretch   <= 1'b0;
      baud_tick <= 1'b0;
    end else begin
      baud_tick <= 1'b0;
      if (src_tick) begin
        if (cnt + 1'b1 >= target) begin
          cnt       <= '0;
          baud_tick <= 1'b1;
          if (frac_act) begin
            {stretch, acc} <= acc_sum;
          end else begin
            stretch <= 1'b0;
            acc     <= '0;
          end
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/frac_baud_gen.sv
module frac_baud_gen
  import fbg_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               uart_mode,
  input  logic [SRC_NUM-1:0] pre_tick,
  input  logic               wr_en,
  input  logic               wr_sel,
  input  logic [DATA_W-1:0]  wr_data,
  input  logic               rd_sel,
  output logic [DATA_W-1:0]  rd_data,
  output logic               baud_tick
);
  cfg_t              cfg;
  logic              restart;
  logic              src_tick;
  logic [CNT_W-1:0]  eff_n;
  logic [FRAC_W-1:0] step;
  logic              frac_act;
  logic              n_bad;

  fbg_regs u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel(rd_sel), .cfg(cfg), .restart(restart), .rd_data(rd_data)
  );

  fbg_tick_sel u_sel (
    .pre_tick(pre_tick), .sel(cfg.src), .src_tick(src_tick)
  );

  fbg_legal u_legal (
    .n(cfg.n), .k(cfg.k), .frac_en(cfg.frac_en), .uart_mode(uart_mode),
    .eff_n(eff_n), .step(step), .frac_act(frac_act), .n_bad(n_bad)
  );

  fbg_divider u_div (
    .clk(clk), .rst(rst), .restart(restart), .hold(n_bad), .src_tick(src_tick),
    .frac_act(frac_act), .eff_n(eff_n), .step(step), .baud_tick(baud_tick)
  );
endmodule

// File: rtl/fbg_checker.sv
module fbg_checker #(
  parameter int DATA_W = 8,
  parameter int FRAC_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic              rd_sel,
  input logic              src_tick,
  input logic              n_bad,
  input logic              baud_tick,
  input logic [DATA_W-1:0] rd_data
);
  AST_TICK_FOLLOWS_SRC: assert property (@(posedge clk) disable iff (rst)
    baud_tick |-> $past(src_tick)); // R7

  AST_BAD_N_SILENT: assert property (@(posedge clk) disable iff (rst)
    n_bad |=> !baud_tick); // R6

  AST_WRITE_RESTART: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> !baud_tick); // R8

  AST_CTRL_TOP_ZERO: assert property (@(posedge clk) disable iff (rst)
    !rd_data[DATA_W-1]); // R9

  AST_FRAC_HIGH_ZERO: assert property (@(posedge clk) disable iff (rst)
    $past(rd_sel) |-> (rd_data[DATA_W-1:FRAC_W] == '0)); // R9
endmodule

bind frac_baud_gen fbg_checker #(.DATA_W(fbg_pkg::DATA_W), .FRAC_W(fbg_pkg::FRAC_W)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .rd_sel(rd_sel), .src_tick(src_tick),
  .n_bad(n_bad), .baud_tick(baud_tick), .rd_data(rd_data)
);

// File: tb/frac_baud_gen_test.sv
`timescale 1ns/1ps
module frac_baud_gen_test;
  import fbg_pkg::*;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              uart_mode = 1'b1;
  logic [SRC_NUM-1:0] pre_tick;
  logic              wr_en = 1'b0;
  logic              wr_sel = 1'b0;
  logic [DATA_W-1:0] wr_data = '0;
  logic              rd_sel = 1'b0;
  logic [DATA_W-1:0] rd_data;
  logic              baud_tick;
  logic [7:0]        psc = '0;
  int checks = 0;
  int fails = 0;
  int cyc = 0;

  // fields: [32:25] control, [24:17] fraction, [16] uart_mode, [15:0] strobe-clock total over 16 periods
  localparam logic [32:0] VECS [12] = '{
    {8'h04, 8'h00, 1'b1, 16'd64},    // R2 N=4 src0
    {8'h00, 8'h00, 1'b1, 16'd256},   // R2 code 0 -> N=16
    {8'h13, 8'h00, 1'b1, 16'd96},    // R1 src1 N=3
    {8'h25, 8'h00, 1'b1, 16'd640},   // R1 src2 N=5
    {8'h45, 8'hA4, 1'b1, 16'd92},    // R3 N=5 K=4, unused fraction bits set
    {8'h52, 8'h0F, 1'b1, 16'd66},    // R3 src1 N=2 K=15
    {8'h01, 8'h00, 1'b1, 16'd16},    // R6 N=1 legal
    {8'h43, 8'h00, 1'b1, 16'd48},    // R4 enable with K=0
    {8'h43, 8'h08, 1'b0, 16'd48},    // R5 I/O mode forces plain
    {8'h32, 8'h00, 1'b1, 16'd1024},  // R1 src3 N=2
    {8'h47, 8'h01, 1'b1, 16'd127},   // R3 N=7 K=1
    {8'h82, 8'h00, 1'b1, 16'd32}     // R9 unused control bit written
  };

  always #2 clk = ~clk;

  always @(negedge clk) psc <= psc + 8'd1;
  assign pre_tick = {psc[4:0] == 5'd0, psc[2:0] == 3'd0, psc[0] == 1'b0, 1'b1};

  frac_baud_gen uut (
    .clk(clk), .rst(rst), .uart_mode(uart_mode), .pre_tick(pre_tick),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data), .rd_sel(rd_sel),
    .rd_data(rd_data), .baud_tick(baud_tick)
  );

  function automatic string tag_of(int i);
    case (i)
      0, 1:         return "R2";
      2, 3, 9:      return "R1";
      4, 5, 10:     return "R3";
      6:            return "R6";
      7:            return "R4";
      8:            return "R5";
      default:      return "R9";
    endcase
  endfunction

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(logic sel, logic [7:0] data);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = data;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic sel, output logic [7:0] v);
    @(negedge clk);
    rd_sel = sel;
    @(negedge clk);
    v = rd_data;
  endtask

  task automatic wait_tick(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!baud_tick && n < 3000);
    if (!baud_tick) n = -1;
  endtask

  task automatic count_ticks(int len, output int n);
    n = 0;
    repeat (len) begin
      @(negedge clk);
      if (baud_tick) n++;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      checks++;
      fails++;
      $display("FAIL watchdog (all requirements): got timeout expected completion");
      summary();
    end
  end

  initial begin
    logic [7:0] v;
    int n;
    repeat (3) @(negedge clk);
    check("R11 tick in reset", int'(baud_tick), 0);
    check("R11 read data in reset", int'(rd_data), 0);
    rst = 1'b0;
    wait_tick(n);
    check("R11 first tick after reset (N=16)", n, 16);
    rd(1'b0, v);
    check("R10 control after reset", int'(v), 0);
    rd(1'b1, v);
    check("R10 fraction after reset", int'(v), 0);

    // vector table
    for (int i = 0; i < 12; i++) begin
      logic [7:0] c;
      logic [7:0] f;
      int nn;
      int d;
      int sum;
      int bad;
      bit fon;
      c = VECS[i][32:25];
      f = VECS[i][24:17];
      uart_mode = VECS[i][16];
      nn = (c[3:0] == 4'd0) ? 16 : int'(c[3:0]);
      case (c[5:4])
        2'd0: d = 1;
        2'd1: d = 2;
        2'd2: d = 8;
        default: d = 32;
      endcase
      fon = c[6] && (f[3:0] != 4'd0) && VECS[i][16] && (nn != 1);
      wr(1'b1, f);
      wr(1'b0, c);
      check("R8 no tick after write", int'(baud_tick), 0);
      wait_tick(n);
      sum = 0;
      bad = 0;
      for (int p = 0; p < 16; p++) begin
        wait_tick(n);
        sum += n;
        if (n != nn * d && !(fon && n == (nn + 1) * d)) bad++;
      end
      check($sformatf("%s vector %0d total", tag_of(i), i), sum, int'(VECS[i][15:0]));
      check($sformatf("R3 vector %0d period lengths out of range", i), bad, 0);
    end

    // restart latency
    uart_mode = 1'b1;
    wr(1'b1, 8'h00);
    wr(1'b0, 8'h0A);
    wait_tick(n);
    check("R8 first tick after write", n, 10);
    @(negedge clk);
    check("R7 tick lasts one clock", int'(baud_tick), 0);
    repeat (3) @(negedge clk);
    wr(1'b0, 8'h0A);
    wait_tick(n);
    check("R8 mid-count restart", n, 10);

    // N=1 legality
    uart_mode = 1'b0;
    wr(1'b0, 8'h01);
    count_ticks(100, n);
    check("R6 N=1 in I/O mode silent", n, 0);
    uart_mode = 1'b1;
    wr(1'b1, 8'h04);
    wr(1'b0, 8'h41);
    count_ticks(100, n);
    check("R6 N=1 with fraction silent", n, 0);
    wr(1'b1, 8'h00);
    wr(1'b0, 8'h01);
    count_ticks(20, n);
    check("R6 N=1 legal ticks every strobe", n, 20);

    // register layout and readback
    wr(1'b0, 8'hFF);
    rd(1'b0, v);
    check("R9 control readback masks bit 7", int'(v), 'h7F);
    wr(1'b1, 8'hA4);
    rd(1'b1, v);
    check("R9 fraction readback masks high bits", int'(v), 'h04);
    rd(1'b0, v);
    check("R10 control unchanged by fraction write", int'(v), 'h7F);

    summary();
  end
endmodule